// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block chooses which of five interrupt sources a small 8-bit processor core services next. The sources are two external requests, two timer overflows and one serial source. The serial source is raised by either a transmit flag or a receive flag. Software writes an enable register and a level register. The enable register has one bit per source plus a global bit. The level register places each source in a high or a low service level.

Requests are captured on a sample strobe that the core issues during an instruction. At the instruction-end strobe, the block decides from the captured requests alone whether to divert the core. The decision also uses two in-service flops, one per level. When the block diverts the core, it raises a one-cycle vector pulse. The pulse carries the routine start address and the source index. With the same pulse, the block strobes a clear for the request flags that hardware is meant to clear. A return pulse from the core ends the innermost active level.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset both in-service flops are clear, `vec_valid` and `flag_clr` are low, and both configuration registers are zero, so sampled requests produce no vector.
- R2: A write with `cfg_sel`=0 loads the enable register. Bits 0..4 enable the sources in index order: external 0 = 0, timer 0 = 1, external 1 = 2, timer 1 = 3, serial = 4. Bit 7 is the global enable. A source can be vectored only when its own bit and bit 7 are both 1.
- R3: A write with `cfg_sel`=1 loads the level register. Bit i = 1 puts source i in the high level and 0 puts it in the low level. A pending high-level source wins over any low-level source, whatever their indices.
- R4: Among eligible sources of the same level, the lowest index wins.
- R5: A vector appears as `vec_valid` high for one cycle, in the cycle after the clock edge that samples `insn_end`. It carries `vec_addr` = 3 + 8 × index and `vec_src` = index.
- R6: The decision uses only the request values captured at the most recent `sample_stb`. A request that changes after that sample is not seen.
- R7: With only the low flop set, an eligible high-level request is vectored and sets `isr_high`.
- R8: No vector is taken while `isr_high` is set. While `isr_low` is set, low-level requests are not vectored.
- R9: A `reti` pulse clears `isr_high` if it is set, otherwise clears `isr_low`. With neither flop set it has no effect.
- R10: When a high routine nested over a low one returns, `isr_low` stays set. After that, low-level requests stay blocked and high-level requests are vectored again.
- R11: With a vector, `flag_clr` has exactly the bit of the vectored source set for sources 0..3. A serial vector, from either flag, clears nothing.
- R12: The captured request of a vectored source is dropped, so it is not vectored again before the next sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects enable register, 1 selects level register |
| cfg_data | input | 8 | Configuration write data |
| hw_req | input | 4 | Hardware-cleared request flags, index 0..3 |
| ser_tx_flag | input | 1 | Serial transmit flag (software-cleared) |
| ser_rx_flag | input | 1 | Serial receive flag (software-cleared) |
| sample_stb | input | 1 | Capture requests |
| insn_end | input | 1 | Instruction boundary, vector decision point |
| reti | input | 1 | Return-from-interrupt pulse |
| vec_valid | output | 1 | One-cycle vector pulse |
| vec_addr | output | 16 | Routine start address |
| vec_src | output | 3 | Vectored source index |
| flag_clr | output | 4 | Clear strobe for hardware-cleared flags |
| isr_high | output | 1 | High level in service |
| isr_low | output | 1 | Low level in service |

## Verification
The bench builds the block with its default parameters: five sources, an 8-bit configuration word with the global enable at bit 7, and vectors at base 3 with a stride of 8. These values bring every vector address and the single software-cleared source within reach of directed scenarios. The scenarios cover the full polling order, each blocking condition of two-level nesting, and the return from a nested routine. They also cover requests that change between the sample and the boundary.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic {
    CFG_ENABLE = 1'b0,
    CFG_LEVEL  = 1'b1
  } cfg_sel_e;

  // start address of a source's routine
  function automatic logic [31:0] vec_addr_of(input int unsigned idx,
                                              input int unsigned base,
                                              input int unsigned stride);
    return 32'(base + idx * stride);
  endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int NUM_SRC = 5,
  parameter int DATA_W  = 8,
  parameter int GEN_BIT = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [NUM_SRC-1:0] src_en,
  output logic               glb_en,
  output logic [NUM_SRC-1:0] hi_level
);
  import irq_pkg::*;

  logic [DATA_W-1:0] en_q;
  logic [DATA_W-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      lvl_q <= '0;
    end else if (wr_en) begin
      if (cfg_sel_e'(wr_sel) == CFG_ENABLE) en_q  <= wr_data;
      else                                  lvl_q <= wr_data;
    end
  end

  assign src_en   = en_q[NUM_SRC-1:0];
  assign glb_en   = en_q[GEN_BIT];
  assign hi_level = lvl_q[NUM_SRC-1:0];

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{en_q, lvl_q};

  // R2: a write to one register leaves the other untouched
  a_r2_sel_isolates: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> $stable(en_q));
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int NUM_SRC = 5,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample_stb,
  input  logic [NUM_SRC-1:0] raw_req,
  input  logic               drop_en,
  input  logic [IDX_W-1:0]   drop_idx,
  output logic [NUM_SRC-1:0] lat_req
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)                                  lat_req[i] <= 1'b0;
      else if (sample_stb)                         lat_req[i] <= raw_req[i];
      else if (drop_en && drop_idx == IDX_W'(i))   lat_req[i] <= 1'b0;
    end
  end

  // R6: captured requests only move on a sample or a drop
  a_r6_hold_between_samples: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_stb && !drop_en) |=> $stable(lat_req));

  // R12: a dropped source is gone in the next cycle unless resampled
  a_r12_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_en && !sample_stb) |=> !lat_req[$past(drop_idx)]);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NUM_SRC = 5,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] lat_req,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic               glb_en,
  input  logic [NUM_SRC-1:0] hi_level,
  input  logic               busy_hi,
  input  logic               busy_lo,
  output logic               win_valid,
  output logic [IDX_W-1:0]   win_idx,
  output logic               win_hi
);
  function automatic logic [IDX_W-1:0] lowest_set(input logic [NUM_SRC-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  logic [NUM_SRC-1:0] eligible;
  logic [NUM_SRC-1:0] hi_cand;
  logic [NUM_SRC-1:0] lo_cand;
  logic               hi_ok;
  logic               lo_ok;

  assign eligible = lat_req & src_en & {NUM_SRC{glb_en}};
  assign hi_cand  = eligible & hi_level;
  assign lo_cand  = eligible & ~hi_level;
  assign hi_ok    = !busy_hi && (|hi_cand);
  assign lo_ok    = !busy_hi && !busy_lo && (|lo_cand);

  always_comb begin
    win_valid = hi_ok || lo_ok;
    win_hi    = hi_ok;
    win_idx   = hi_ok ? lowest_set(hi_cand) : lowest_set(lo_cand);
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
  parameter int NUM_SRC    = 5,
  parameter int DATA_W     = 8,
  parameter int GEN_BIT    = 7,
  parameter int ADDR_W     = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam int NUM_HW = NUM_SRC - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic [NUM_HW-1:0] hw_req,
  input  logic              ser_tx_flag,
  input  logic              ser_rx_flag,
  input  logic              sample_stb,
  input  logic              insn_end,
  input  logic              reti,
  output logic              vec_valid,
  output logic [ADDR_W-1:0] vec_addr,
  output logic [IDX_W-1:0]  vec_src,
  output logic [NUM_HW-1:0] flag_clr,
  output logic              isr_high,
  output logic              isr_low
);
  import irq_pkg::*;

  logic [NUM_SRC-1:0] src_en, hi_level, lat_req, raw_req;
  logic               glb_en;
  logic               win_valid, win_hi;
  logic [IDX_W-1:0]   win_idx;
  logic               take;        // vector decided this cycle
  logic               isr_hi_q, isr_lo_q;

  assign raw_req = {ser_tx_flag | ser_rx_flag, hw_req};
  assign take    = insn_end && win_valid;

  irq_cfg_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .GEN_BIT(GEN_BIT)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_sel(cfg_sel), .wr_data(cfg_data),
    .src_en(src_en), .glb_en(glb_en), .hi_level(hi_level)
  );

  irq_req_latch #(.NUM_SRC(NUM_SRC)) u_latch (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .raw_req(raw_req),
    .drop_en(take), .drop_idx(win_idx), .lat_req(lat_req)
  );

  irq_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .lat_req(lat_req), .src_en(src_en), .glb_en(glb_en), .hi_level(hi_level),
    .busy_hi(isr_hi_q), .busy_lo(isr_lo_q),
    .win_valid(win_valid), .win_idx(win_idx), .win_hi(win_hi)
  );

  // in-service flops: return first, then a new entry
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr_hi_q <= 1'b0;
      isr_lo_q <= 1'b0;
    end else begin
      if (reti) begin
        if (isr_hi_q)      isr_hi_q <= 1'b0;
        else if (isr_lo_q) isr_lo_q <= 1'b0;
      end
      if (take) begin
        if (win_hi) isr_hi_q <= 1'b1;
        else        isr_lo_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec_addr  <= '0;
      vec_src   <= '0;
    end else begin
      vec_valid <= take;
      vec_src   <= take ? win_idx : '0;
      vec_addr  <= take ? ADDR_W'(vec_addr_of(int'(win_idx), VEC_BASE, VEC_STRIDE)) : '0;
    end
  end

  for (genvar i = 0; i < NUM_HW; i++) begin : g_clr
    always_ff @(posedge clk) begin
      if (!rst_n) flag_clr[i] <= 1'b0;
      else        flag_clr[i] <= take && win_idx == IDX_W'(i);
    end
  end

  assign isr_high = isr_hi_q;
  assign isr_low  = isr_lo_q;

  // R11: clear strobe only together with a vector, at most one bit
  a_r11_clr_with_vec: assert property (@(posedge clk) disable iff (!rst_n)
    (|flag_clr) |-> vec_valid);
  a_r11_clr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flag_clr));
  // R8: nothing is vectored out of a high routine
  a_r8_high_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> !$past(isr_hi_q));
  // R8: a vector taken during a low routine must be high level
  a_r8_low_blocks_low: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && $past(isr_lo_q)) |-> isr_hi_q);
  // R2: no vector without the global enable
  a_r2_needs_global: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> glb_en);
  // R10: leaving a high routine keeps the low flop as it was
  a_r10_low_survives: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && isr_hi_q) |=> (isr_lo_q == $past(isr_lo_q)) && !isr_hi_q);
  // R9: a return with nothing in service changes nothing
  a_r9_idle_return: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !isr_hi_q && !isr_lo_q && !take) |=> (!isr_hi_q && !isr_lo_q));
endmodule

// File: tb/test_irq_vec_ctrl.sv
module test_irq_vec_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0, cfg_sel = 1'b0;
  logic [7:0] cfg_data = '0;
  logic [3:0] hw_req = '0;
  logic       ser_tx_flag = 1'b0, ser_rx_flag = 1'b0;
  logic       sample_stb = 1'b0, insn_end = 1'b0, reti = 1'b0;
  logic       vec_valid;
  logic [15:0] vec_addr;
  logic [2:0] vec_src;
  logic [3:0] flag_clr;
  logic       isr_high, isr_low;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_vec_ctrl i_irq_vec_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .hw_req(hw_req), .ser_tx_flag(ser_tx_flag), .ser_rx_flag(ser_rx_flag),
    .sample_stb(sample_stb), .insn_end(insn_end), .reti(reti),
    .vec_valid(vec_valid), .vec_addr(vec_addr), .vec_src(vec_src),
    .flag_clr(flag_clr), .isr_high(isr_high), .isr_low(isr_low)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input bit sel, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_data = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic sample(input logic [3:0] hw, input bit tx, input bit rx);
    @(negedge clk);
    hw_req = hw; ser_tx_flag = tx; ser_rx_flag = rx; sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
  endtask

  // pulse the boundary; the registered vector is visible one negedge later
  task automatic boundary(input bit exp_v, input int exp_idx, input string tag);
    int exp_addr;
    int exp_clr;
    @(negedge clk);
    insn_end = 1'b1;
    @(negedge clk);
    insn_end = 1'b0;
    check(vec_valid == exp_v, {tag, " vec_valid"}, vec_valid, exp_v);
    if (exp_v) begin
      exp_addr = 32'h3 | (exp_idx << 3);
      exp_clr  = (exp_idx == 4) ? 0 : (1 << exp_idx);
      check(int'(vec_addr) == exp_addr, {tag, " vec_addr"}, vec_addr, exp_addr);
      check(int'(vec_src) == exp_idx, {tag, " vec_src"}, vec_src, exp_idx);
      check(int'(flag_clr) == exp_clr, {tag, " R11 flag_clr"}, flag_clr, exp_clr);
    end else begin
      check(flag_clr == 4'h0, {tag, " R11 flag_clr idle"}, flag_clr, 0);
    end
    @(negedge clk);
    check(vec_valid == 1'b0, {tag, " R5 single pulse"}, vec_valid, 0);
  endtask

  task automatic do_reti(input bit exp_hi, input bit exp_lo, input string tag);
    @(negedge clk);
    reti = 1'b1;
    @(negedge clk);
    reti = 1'b0;
    check(isr_high == exp_hi, {tag, " isr_high"}, isr_high, exp_hi);
    check(isr_low == exp_lo, {tag, " isr_low"}, isr_low, exp_lo);
  endtask

  task automatic t_reset();
    check(vec_valid == 1'b0 && flag_clr == 4'h0, "R1 outputs after reset", vec_valid, 0);
    check(!isr_high && !isr_low, "R1 flops after reset", {isr_high, isr_low}, 0);
    sample(4'hF, 1'b1, 1'b0);
    boundary(1'b0, 0, "R1 unconfigured");
  endtask

  task automatic t_enable();
    cfg(1'b0, 8'h1F);
    sample(4'h1, 1'b0, 1'b0);
    boundary(1'b0, 0, "R2 no global");
    cfg(1'b0, 8'h9F);
    boundary(1'b1, 0, "R2 global on");
    check(isr_low && !isr_high, "R2 low level entered", {isr_high, isr_low}, 1);
    do_reti(1'b0, 1'b0, "R9 low return");
    cfg(1'b0, 8'h9E);
    sample(4'h1, 1'b0, 1'b0);
    boundary(1'b0, 0, "R2 own bit off");
    cfg(1'b0, 8'h9F);
  endtask

  task automatic t_order();
    sample(4'hF, 1'b1, 1'b0);
    for (int k = 0; k < 5; k++) begin
      boundary(1'b1, k, $sformatf("R4 R5 order step %0d", k));
      do_reti(1'b0, 1'b0, "R9 order return");
    end
    boundary(1'b0, 0, "R12 all dropped");
    sample(4'h0, 1'b0, 1'b1);
    boundary(1'b1, 4, "R11 serial via receive");
    do_reti(1'b0, 1'b0, "R9 serial return");
  endtask

  task automatic t_latch();
    sample(4'h0, 1'b0, 1'b0);
    @(negedge clk);
    hw_req = 4'h1;
    boundary(1'b0, 0, "R6 unsampled change");
    sample(4'h1, 1'b0, 1'b0);
    boundary(1'b1, 0, "R6 after sample");
    do_reti(1'b0, 1'b0, "R9 latch return");
    boundary(1'b0, 0, "R12 no repeat");
  endtask

  task automatic t_nest();
    cfg(1'b1, 8'h08);
    sample(4'h9, 1'b0, 1'b0);
    boundary(1'b1, 3, "R3 high beats lower index");
    check(isr_high && !isr_low, "R3 high entered", {isr_high, isr_low}, 2);
    do_reti(1'b0, 1'b0, "R9 high return");
    boundary(1'b1, 0, "R12 remaining low source");
    sample(4'h4, 1'b0, 1'b0);
    boundary(1'b0, 0, "R8 low over low");
    sample(4'h8, 1'b0, 1'b0);
    boundary(1'b1, 3, "R7 high over low");
    check(isr_high && isr_low, "R7 both set", {isr_high, isr_low}, 3);
    sample(4'h8, 1'b0, 1'b0);
    boundary(1'b0, 0, "R8 high over high");
    do_reti(1'b0, 1'b1, "R10 nested return");
    sample(4'h4, 1'b0, 1'b0);
    boundary(1'b0, 0, "R10 low still blocked");
    sample(4'h8, 1'b0, 1'b0);
    boundary(1'b1, 3, "R10 high accepted again");
    do_reti(1'b0, 1'b1, "R10 second nested return");
    do_reti(1'b0, 1'b0, "R9 low cleared");
    do_reti(1'b0, 1'b0, "R9 idle return");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_order();
    t_latch();
    t_nest();
    summary();
    $finish;
  end
endmodule